// File: doc/BRIEF.md
# Unlock-Gated Cartridge Configuration Register Bank

This block sits on the write side of a 16-bit memory-mapped cartridge bus and holds the configuration that the rest of the cartridge logic reads: a ROM page selector, an SD control word, a 32-bit sector address and a 16-bit sector count/command word. Every bus write is a halfword access, so only address bits [27:1] are presented and compared.

Configuration writes are guarded. A write to a register address changes nothing unless the bank has been opened first. Opening takes four consecutive writes, each to a specific address with a specific key value. The bank then stays open across any number of writes until a lock write closes it. A write that departs from the key sequence sends the tracker back to its start. One key write is special: it always begins a fresh attempt.

Whenever the command word is written inside the open window, the block emits a one-cycle pulse. This pulse tells the downstream transfer engine that a new request is waiting.

Top module: `cart_cfg_regs`

## Requirements
- R1: After reset the ROM page is 0x0200, the SD enable and read-select outputs are 0, the sector address and command word are 0, the command pulse is 0 and the window is closed (`cfg_open` = 0).
- R2: The window opens after four consecutive writes: 0xD200 to byte address 0x09FE0000, 0x1500 to 0x08000000, 0xD200 to 0x08020000, then 0x1500 to 0x08040000. `cfg_open` rises one clock after the fourth write.
- R3: While the window is closed, writes to any register address leave every register output unchanged.
- R4: While the window is closed, a write whose address or data does not match the next expected key returns the tracker to its initial state. A full four-write sequence is then needed to open the window.
- R5: While the window is closed, a write of 0xD200 to 0x09FE0000 always counts as the first key, even in the middle of an attempt. The next expected write is then the second key.
- R6: While the window is open, a write of 0x1500 to 0x09FC0000 closes it, and later register writes are ignored. A write to that address with any other value leaves the window open.
- R7: While the window is open, a write to 0x09880000 loads the 16-bit ROM page (0x8002 selects the kernel map, 0x0200 the PSRAM map).
- R8: While the window is open, a write to 0x09400000 loads SD control: data bit 0 drives `sd_enable` and data bit 1 drives `sd_read_sel`.
- R9: While the window is open, writes to 0x09600000 and 0x09620000 load bits [15:0] and [31:16] of `sector_addr`.
- R10: While the window is open, a write to 0x09640000 loads `sector_cmd`. `cmd_pulse` is high for exactly the one cycle after that write.
- R11: While the window is open, a write to any other address changes no register and does not close the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | 27 | Halfword address, byte-address bits [27:1] |
| wr_data | input | 16 | Write data |
| rom_page | output | 16 | ROM page register |
| sd_enable | output | 1 | SD enable control bit |
| sd_read_sel | output | 1 | SD read-state select bit |
| sector_addr | output | 32 | Sector address |
| sector_cmd | output | 16 | Sector count/command word |
| cmd_pulse | output | 1 | One-cycle pulse after a command write |
| cfg_open | output | 1 | Window open flag |

## Verification
Each write is sampled on one rising edge. Its register effects, the change in `cfg_open` and `cmd_pulse` all appear together after that same edge, and `cmd_pulse` drops again one edge later. The driver task holds each write for exactly one edge. It then queues the expected full output state, and the monitor checks that state on the next falling edge, which is the first half-cycle where the result is due. Idle cycles also queue an expected state, so the bench confirms both that the pulse is gone and that nothing else moved.

// File: rtl/cart_cfg_pkg.sv
package cart_cfg_pkg;
  localparam int HW_ADDR_W = 27;
  localparam int DATA_W    = 16;

  typedef logic [HW_ADDR_W-1:0] hw_addr_t;

  localparam logic [DATA_W-1:0] KEY_A = 16'hD200;
  localparam logic [DATA_W-1:0] KEY_B = 16'h1500;

  // decoded address slots
  localparam int SLOT_K0   = 0;
  localparam int SLOT_K1   = 1;
  localparam int SLOT_K2   = 2;
  localparam int SLOT_K3   = 3;
  localparam int SLOT_LOCK = 4;
  localparam int SLOT_PAGE = 5;
  localparam int SLOT_SDC  = 6;
  localparam int SLOT_SLO  = 7;
  localparam int SLOT_SHI  = 8;
  localparam int SLOT_CMD  = 9;
  localparam int NUM_SLOT  = 10;

  function automatic logic [31:0] slot_byte_addr(input int idx);
    case (idx)
      SLOT_K0:   return 32'h09FE_0000;
      SLOT_K1:   return 32'h0800_0000;
      SLOT_K2:   return 32'h0802_0000;
      SLOT_K3:   return 32'h0804_0000;
      SLOT_LOCK: return 32'h09FC_0000;
      SLOT_PAGE: return 32'h0988_0000;
      SLOT_SDC:  return 32'h0940_0000;
      SLOT_SLO:  return 32'h0960_0000;
      SLOT_SHI:  return 32'h0962_0000;
      default:   return 32'h0964_0000;
    endcase
  endfunction

  function automatic hw_addr_t to_hw(input logic [31:0] byte_addr);
    return byte_addr[HW_ADDR_W:1];
  endfunction

  typedef enum logic [2:0] {
    UST_IDLE = 3'd0,
    UST_K1   = 3'd1,
    UST_K2   = 3'd2,
    UST_K3   = 3'd3,
    UST_OPEN = 3'd4
  } unl_state_e;
endpackage

// File: rtl/cart_cfg_decode.sv
module cart_cfg_decode
  import cart_cfg_pkg::*;
(
  input  logic [HW_ADDR_W-1:0] wr_addr,
  output logic [NUM_SLOT-1:0]  slot_hit
);
  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    localparam hw_addr_t SLOT_HW = to_hw(slot_byte_addr(g));
    assign slot_hit[g] = (wr_addr == SLOT_HW);
  end
endmodule

// File: rtl/cart_cfg_unlock.sv
module cart_cfg_unlock
  import cart_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hit_k0,
  input  logic              hit_k1,
  input  logic              hit_k2,
  input  logic              hit_k3,
  input  logic              hit_lock,
  output logic              win_open
);
  unl_state_e st_q, st_d;
  logic is_a, is_b;

  assign is_a = (wr_data == KEY_A);
  assign is_b = (wr_data == KEY_B);

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      if (st_q == UST_OPEN) begin
        if (hit_lock && is_b) st_d = UST_IDLE;
      end else if (hit_k0 && is_a) begin
        st_d = UST_K1;
      end else begin
        case (st_q)
          UST_K1:  st_d = (hit_k1 && is_b) ? UST_K2 : UST_IDLE;
          UST_K2:  st_d = (hit_k2 && is_a) ? UST_K3 : UST_IDLE;
          UST_K3:  st_d = (hit_k3 && is_b) ? UST_OPEN : UST_IDLE;
          default: st_d = UST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UST_IDLE;
    else        st_q <= st_d;
  end

  assign win_open = (st_q == UST_OPEN);

  // R2
  open_from_k3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(st_q == UST_K3 && wr_en && hit_k3 && is_b));

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_k0 && is_a && st_q != UST_OPEN) |=> (st_q == UST_K1));

  // R6
  lock_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && wr_en && hit_lock && is_b) |=> !win_open);

  // R11
  open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && !(wr_en && hit_lock)) |=> win_open);
endmodule

// File: rtl/cart_cfg_regfile.sv
module cart_cfg_regfile
  import cart_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_PAGE = 16'h0200,
  parameter int                SADDR_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               win_open,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               hit_page,
  input  logic               hit_sdc,
  input  logic               hit_slo,
  input  logic               hit_shi,
  input  logic               hit_cmd,
  output logic [DATA_W-1:0]  rom_page,
  output logic [1:0]         sd_ctrl,
  output logic [SADDR_W-1:0] sector_addr,
  output logic [DATA_W-1:0]  sector_cmd,
  output logic               cmd_pulse
);
  localparam int HALF_W = SADDR_W / 2;

  logic load;
  logic page_en, sdc_en, slo_en, shi_en, cmd_en;
  logic [DATA_W-1:0]  page_q, cmd_q;
  logic [1:0]         sdc_q;
  logic [HALF_W-1:0]  slo_q, shi_q;
  logic               pulse_q, pulse_d;

  assign load    = wr_en && win_open;
  assign page_en = load && hit_page;
  assign sdc_en  = load && hit_sdc;
  assign slo_en  = load && hit_slo;
  assign shi_en  = load && hit_shi;
  assign cmd_en  = load && hit_cmd;
  assign pulse_d = cmd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= RESET_PAGE;
      sdc_q   <= '0;
      slo_q   <= '0;
      shi_q   <= '0;
      cmd_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (page_en) page_q <= wr_data;
      if (sdc_en)  sdc_q  <= wr_data[1:0];
      if (slo_en)  slo_q  <= wr_data[HALF_W-1:0];
      if (shi_en)  shi_q  <= wr_data[HALF_W-1:0];
      if (cmd_en)  cmd_q  <= wr_data;
      pulse_q <= pulse_d;
    end
  end

  assign rom_page    = page_q;
  assign sd_ctrl     = sdc_q;
  assign sector_addr = {shi_q, slo_q};
  assign sector_cmd  = cmd_q;
  assign cmd_pulse   = pulse_q;

  // R3
  closed_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(rom_page) && $stable(sd_ctrl) && $stable(sector_addr) && $stable(sector_cmd));

  // R10
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse |-> $past(wr_en && win_open && hit_cmd));

  // R7
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win_open && hit_page) |=> rom_page == $past(wr_data));
endmodule

// File: rtl/cart_cfg_regs.sv
module cart_cfg_regs
  import cart_cfg_pkg::*;
#(
  parameter logic [15:0] RESET_PAGE = 16'h0200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [26:0] wr_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rom_page,
  output logic        sd_enable,
  output logic        sd_read_sel,
  output logic [31:0] sector_addr,
  output logic [15:0] sector_cmd,
  output logic        cmd_pulse,
  output logic        cfg_open
);
  logic [NUM_SLOT-1:0] slot_hit;
  logic                win_open;
  logic [1:0]          sd_ctrl;

  cart_cfg_decode u_decode (
    .wr_addr  (wr_addr),
    .slot_hit (slot_hit)
  );

  cart_cfg_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .hit_k0   (slot_hit[SLOT_K0]),
    .hit_k1   (slot_hit[SLOT_K1]),
    .hit_k2   (slot_hit[SLOT_K2]),
    .hit_k3   (slot_hit[SLOT_K3]),
    .hit_lock (slot_hit[SLOT_LOCK]),
    .win_open (win_open)
  );

  cart_cfg_regfile #(
    .RESET_PAGE (RESET_PAGE),
    .SADDR_W    (32)
  ) u_regfile (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .win_open    (win_open),
    .wr_data     (wr_data),
    .hit_page    (slot_hit[SLOT_PAGE]),
    .hit_sdc     (slot_hit[SLOT_SDC]),
    .hit_slo     (slot_hit[SLOT_SLO]),
    .hit_shi     (slot_hit[SLOT_SHI]),
    .hit_cmd     (slot_hit[SLOT_CMD]),
    .rom_page    (rom_page),
    .sd_ctrl     (sd_ctrl),
    .sector_addr (sector_addr),
    .sector_cmd  (sector_cmd),
    .cmd_pulse   (cmd_pulse)
  );

  assign sd_enable   = sd_ctrl[0];
  assign sd_read_sel = sd_ctrl[1];
  assign cfg_open    = win_open;

  // R1
  reset_page_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (rom_page == RESET_PAGE && !cfg_open && !cmd_pulse));
endmodule

// File: tb/cart_cfg_regs_tb.sv
module cart_cfg_regs_tb;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [26:0] wr_addr;
  logic [15:0] wr_data;
  logic [15:0] rom_page;
  logic        sd_enable, sd_read_sel, cmd_pulse, cfg_open;
  logic [31:0] sector_addr;
  logic [15:0] sector_cmd;

  cart_cfg_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rom_page(rom_page), .sd_enable(sd_enable), .sd_read_sel(sd_read_sel),
    .sector_addr(sector_addr), .sector_cmd(sector_cmd), .cmd_pulse(cmd_pulse),
    .cfg_open(cfg_open)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    string       tag;
    logic        open;
    logic [15:0] page;
    logic [1:0]  sdc;
    logic [31:0] saddr;
    logic [15:0] cmd;
    logic        pulse;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model of the requirements
  int          m_step;   // 0 idle, 1..3 keys seen, 4 open
  logic [15:0] m_page;
  logic [1:0]  m_sdc;
  logic [31:0] m_saddr;
  logic [15:0] m_cmd;

  function automatic logic [26:0] hw(input logic [31:0] b);
    return b[27:1];
  endfunction

  task automatic push(input string tag, input logic pulse);
    exp_t e;
    e.tag = tag; e.open = (m_step == 4); e.page = m_page; e.sdc = m_sdc;
    e.saddr = m_saddr; e.cmd = m_cmd; e.pulse = pulse;
    q.push_back(e);
  endtask

  task automatic wr(input logic [31:0] a, input logic [15:0] d, input string tag);
    logic p;
    p = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = hw(a); wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (m_step == 4) begin
      if (a == 32'h09FC0000 && d == 16'h1500) m_step = 0;
      else if (a == 32'h09880000) m_page = d;
      else if (a == 32'h09400000) m_sdc = d[1:0];
      else if (a == 32'h09600000) m_saddr[15:0] = d;
      else if (a == 32'h09620000) m_saddr[31:16] = d;
      else if (a == 32'h09640000) begin m_cmd = d; p = 1'b1; end
    end else if (a == 32'h09FE0000 && d == 16'hD200) m_step = 1;
    else if (m_step == 1 && a == 32'h08000000 && d == 16'h1500) m_step = 2;
    else if (m_step == 2 && a == 32'h08020000 && d == 16'hD200) m_step = 3;
    else if (m_step == 3 && a == 32'h08040000 && d == 16'h1500) m_step = 4;
    else m_step = 0;
    push(tag, p);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk);
    #1;
    push(tag, 1'b0);
  endtask

  task automatic unlock(input string tag);
    wr(32'h09FE0000, 16'hD200, tag);
    wr(32'h08000000, 16'h1500, tag);
    wr(32'h08020000, 16'hD200, tag);
    wr(32'h08040000, 16'h1500, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (cfg_open !== e.open || rom_page !== e.page || {sd_read_sel, sd_enable} !== e.sdc ||
          sector_addr !== e.saddr || sector_cmd !== e.cmd || cmd_pulse !== e.pulse) begin
        failures++;
        $display("FAIL %s: actual open=%0b page=%h sdc=%0d saddr=%h cmd=%h pulse=%0b expected open=%0b page=%h sdc=%0d saddr=%h cmd=%h pulse=%0b",
          e.tag, cfg_open, rom_page, {sd_read_sel, sd_enable}, sector_addr, sector_cmd, cmd_pulse,
          e.open, e.page, e.sdc, e.saddr, e.cmd, e.pulse);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rst_n = 1'b0;
    m_step = 0; m_page = 16'h0200; m_sdc = 2'd0; m_saddr = '0; m_cmd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle("R1 reset state");
    // R3 closed writes ignored
    wr(32'h09880000, 16'h8002, "R3 page write while closed");
    wr(32'h09640000, 16'h0004, "R3 cmd write while closed");
    // R2 unlock
    unlock("R2 unlock sequence");
    // R7 page
    wr(32'h09880000, 16'h8002, "R7 kernel page");
    // R8 sd control
    wr(32'h09400000, 16'h0003, "R8 sd enable+read");
    wr(32'h09400000, 16'h0001, "R8 sd enable");
    wr(32'h09400000, 16'h0002, "R8 read sel only");
    // R9 sector address
    wr(32'h09600000, 16'hBEEF, "R9 sector low");
    wr(32'h09620000, 16'h1234, "R9 sector high");
    // R10 command and pulse
    wr(32'h09640000, 16'h0004, "R10 command write");
    idle("R10 pulse drops");
    wr(32'h09640000, 16'h8001, "R10 back-to-back cmd 1");
    wr(32'h09640000, 16'h0002, "R10 back-to-back cmd 2");
    idle("R10 pulse drops again");
    // R11 other addresses
    wr(32'h09000000, 16'h00F0, "R11 foreign address");
    wr(32'h09FE0000, 16'hD200, "R11 key address while open");
    // R6 lock with wrong data keeps open, then real lock
    wr(32'h09FC0000, 16'h1501, "R6 lock wrong data");
    wr(32'h09FC0000, 16'h1500, "R6 lock write");
    wr(32'h09880000, 16'h1234, "R6 page write after lock");
    wr(32'h09640000, 16'h0009, "R6 cmd after lock no pulse");
    // R4 broken sequences
    wr(32'h09FE0000, 16'hD200, "R4 key0");
    wr(32'h08000000, 16'h1501, "R4 wrong data");
    wr(32'h08020000, 16'hD200, "R4 continue after break");
    wr(32'h08040000, 16'h1500, "R4 must stay closed");
    wr(32'h09FE0000, 16'hD200, "R4 key0 again");
    wr(32'h08000000, 16'h1500, "R4 key1");
    wr(32'h08020002, 16'hD200, "R4 wrong address");
    wr(32'h08040000, 16'h1500, "R4 key3 after break");
    wr(32'h09880000, 16'h5555, "R4 page still locked");
    // R5 restart
    wr(32'h09FE0000, 16'hD200, "R5 key0");
    wr(32'h09FE0000, 16'hD200, "R5 key0 repeated");
    wr(32'h08000000, 16'h1500, "R5 key1");
    wr(32'h09FE0000, 16'hD200, "R5 key0 mid-sequence");
    wr(32'h08000000, 16'h1500, "R5 key1 again");
    wr(32'h08020000, 16'hD200, "R5 key2");
    wr(32'h08040000, 16'h1500, "R5 key3 opens");
    wr(32'h09880000, 16'h0200, "R7 psram page");
    wr(32'h09400000, 16'h0000, "R8 sd disable");
    wr(32'h09FC0000, 16'h1500, "R6 final lock");
    idle("R6 closed at end");
    idle("drain");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule